// File: doc/BRIEF.md
# Maskable Fault Latch Interrupt Controller

This block holds eight sticky fault flags fed by asynchronous fault inputs. Each input passes through a synchroniser and then sets its flag. The flag stays set until the host clears it with a clear command. An eight-bit interrupt mask selects which flags may raise the interrupt. The mask is written as two four-bit halves. The interrupt is a registered, active-high level. It stays high while any enabled flag is set, so a host that services several pending faults sees no gap when one of them is cleared.

Commands come from an external serial front end, which is not part of this block. The front end gives a pulse when a frame opens and a pulse when it closes, and with the closing pulse it presents the eight-bit command word and a frame-valid bit. Commands act only on that closing pulse. A clear is withheld for any flag whose fault input changed while the frame was open. This stops a fault that the host has not yet seen from being lost. The latched flags are exported as the status word that the front end returns to the host.

Top module: `faultIrqTop`

## Requirements
- R1: A fault input held high for at least two clock cycles sets its status bit, which appears at statusOut within three cycles. The bit stays set after the input falls, until a qualifying clear.
- R2: irqOut goes high one cycle after the AND of statusOut and the mask becomes nonzero, and goes low one cycle after it becomes zero. Command upper nibble 0x2 loads the command's low nibble into mask bits 3:0, and upper nibble 0x3 loads it into mask bits 7:4.
- R3: Upper nibble 0x6 clears status bit j (j = 0..3) for each payload bit j that is 1. Upper nibble 0x7 clears status bit j+4 in the same way. No other status bit is affected.
- R4: A mask or clear command takes effect only in the cycle frameEnd is high with frameOk high. With frameOk low, the command changes nothing.
- R5: A status bit whose fault input is still high stays set through a clear.
- R6: A command whose upper three bits are 000, or any other unassigned code, changes no status bit and no mask bit.
- R7: After reset, statusOut is 0x00, the mask is all zero and irqOut is low.
- R8: A clear is withheld for any bit whose synchronised fault input changed between frameStart and frameEnd. The bit stays set.
- R9: When two enabled flags are set and one of them is cleared, irqOut stays high without a low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultIn | input | 8 | Raw fault inputs, asynchronous, active high |
| frameStart | input | 1 | One-cycle pulse when a command frame opens |
| frameEnd | input | 1 | One-cycle pulse when a command frame closes |
| frameOk | input | 1 | Frame had the legal bit count; valid with frameEnd |
| cmdWord | input | 8 | Received command: upper nibble opcode, lower nibble payload |
| statusOut | output | 8 | Latched fault flags |
| irqOut | output | 1 | Registered level interrupt |

## Verification
A corrupted latch shows at statusOut within one cycle of the clear pulse, or within three cycles of a fault pulse. A corrupted mask bit or interrupt register shows at irqOut one cycle later. A wrong change detector shows only when a fault toggles inside a frame: the status bit is then lost on the next clear. The bench therefore toggles a fault inside a frame and reads statusOut right after that frame. It also watches irqOut on every cycle while one of two enabled faults is cleared, to catch a low glitch that a check at the end of the step would miss.

// File: rtl/faultIrqPkg.sv
package faultIrqPkg;
  localparam int GROUP_W = 4;
  localparam int FLAG_W  = 2 * GROUP_W;
  localparam int CMD_W   = 8;

  localparam logic [3:0] OPC_MASK_LO = 4'h2;
  localparam logic [3:0] OPC_MASK_HI = 4'h3;
  localparam logic [3:0] OPC_CLR_LO  = 4'h6;
  localparam logic [3:0] OPC_CLR_HI  = 4'h7;

  typedef struct packed {
    logic               maskLoWr;
    logic               maskHiWr;
    logic               clrLo;
    logic               clrHi;
    logic [GROUP_W-1:0] payload;
    logic               trackRestart;
    logic               trackOn;
  } ctrlStrobes_t;
endpackage

// File: rtl/faultIrqCtrl.sv
module faultIrqCtrl
  import faultIrqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             frameOk,
  input  logic [CMD_W-1:0] cmdWord,
  output ctrlStrobes_t     strb
);
  logic       inFrame;
  logic       cmdValid;
  logic [3:0] opcode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           inFrame <= 1'b0;
    else if (frameStart) inFrame <= 1'b1;
    else if (frameEnd)   inFrame <= 1'b0;
  end

  assign opcode   = cmdWord[CMD_W-1 -: 4];
  assign cmdValid = frameEnd && frameOk;

  always_comb begin
    strb              = '0;
    strb.payload      = cmdWord[GROUP_W-1:0];
    strb.trackRestart = frameStart;
    strb.trackOn      = inFrame;
    if (cmdValid) begin
      unique case (opcode)
        OPC_MASK_LO: strb.maskLoWr = 1'b1;
        OPC_MASK_HI: strb.maskHiWr = 1'b1;
        OPC_CLR_LO:  strb.clrLo    = 1'b1;
        OPC_CLR_HI:  strb.clrHi    = 1'b1;
        default:     ;
      endcase
    end
  end

  // R4: no action strobe without a valid frame end
  assert_valid_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskLoWr || strb.maskHiWr || strb.clrLo || strb.clrHi) |-> (frameEnd && frameOk));

  assert_single_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.maskLoWr, strb.maskHiWr, strb.clrLo, strb.clrHi}));

  // R6: status reads act on nothing
  assert_null_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWord[CMD_W-1 -: 3] == 3'b000) |->
      !(strb.maskLoWr || strb.maskHiWr || strb.clrLo || strb.clrHi));
endmodule

// File: rtl/faultIrqDatapath.sv
module faultIrqDatapath
  import faultIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] faultIn,
  input  ctrlStrobes_t      strb,
  output logic [FLAG_W-1:0] statusOut,
  output logic              irqOut
);
  localparam int NUM_GROUPS = FLAG_W / GROUP_W;

  logic [FLAG_W-1:0] syncStage [SYNC_STAGES];
  logic [FLAG_W-1:0] syncCur;
  logic [FLAG_W-1:0] syncPrev;
  logic [FLAG_W-1:0] changed;
  logic [FLAG_W-1:0] blocked;
  logic [FLAG_W-1:0] clrReq;
  logic [FLAG_W-1:0] clrEff;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] maskReg;
  logic [NUM_GROUPS-1:0] grpMaskWr;
  logic [NUM_GROUPS-1:0] grpClr;
  logic              clrAny;

  // synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncStage[0] <= '0;
    else       syncStage[0] <= faultIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else       syncStage[s] <= syncStage[s-1];
    end
  end

  assign syncCur = syncStage[SYNC_STAGES-1];

  // change detector over the frame window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= '0;
      changed  <= '0;
    end else begin
      syncPrev <= syncCur;
      if (strb.trackRestart)  changed <= '0;
      else if (strb.trackOn)  changed <= changed | (syncCur ^ syncPrev);
    end
  end

  assign blocked = changed | (strb.trackOn ? (syncCur ^ syncPrev) : '0);

  // per-group strobes
  assign grpMaskWr = {strb.maskHiWr, strb.maskLoWr};
  assign grpClr    = {strb.clrHi, strb.clrLo};

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    assign clrReq[g*GROUP_W +: GROUP_W] = grpClr[g] ? strb.payload : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             maskReg[g*GROUP_W +: GROUP_W] <= '0;
      else if (grpMaskWr[g]) maskReg[g*GROUP_W +: GROUP_W] <= strb.payload;
    end
  end

  assign clrEff = clrReq & ~blocked;
  assign clrAny = |grpClr;

  // sticky latches: a live fault wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrEff) | syncCur;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(flags & maskReg);
  end

  assign statusOut = flags;

  // R1: set flags survive any cycle without a clear
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rstN)
    !clrAny |=> ((flags & $past(flags)) == $past(flags)));

  // R2: interrupt level follows enabled flags by one cycle
  assert_irq_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|(flags & maskReg)) |=> irqOut);
  assert_irq_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(|(flags & maskReg)) |=> !irqOut);

  // R5: a live fault is always latched next cycle
  assert_live_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(syncCur)) == $past(syncCur)));

  // R8: bits that toggled in the frame survive the clear
  assert_change_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    clrAny |=> ((flags & $past(flags & blocked)) == $past(flags & blocked)));

  // R4: mask changes only on a write strobe
  assert_mask_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(|grpMaskWr) |=> $stable(maskReg));
endmodule

// File: rtl/faultIrqTop.sv
module faultIrqTop
  import faultIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] faultIn,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              frameOk,
  input  logic [CMD_W-1:0]  cmdWord,
  output logic [FLAG_W-1:0] statusOut,
  output logic              irqOut
);
  ctrlStrobes_t strb;

  faultIrqCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .frameEnd   (frameEnd),
    .frameOk    (frameOk),
    .cmdWord    (cmdWord),
    .strb       (strb)
  );

  faultIrqDatapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .faultIn   (faultIn),
    .strb      (strb),
    .statusOut (statusOut),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/faultIrqTop_tb_top.sv
module faultIrqTop_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] faultIn = '0;
  logic       frameStart = 1'b0;
  logic       frameEnd = 1'b0;
  logic       frameOk = 1'b0;
  logic [7:0] cmdWord = '0;
  logic [7:0] statusOut;
  logic       irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;
  bit watchIrq = 0;
  bit irqDropped = 0;

  string      qTag [$];
  logic [7:0] qStatus [$];
  logic       qIrq [$];

  always #2 clk = ~clk;

  faultIrqTop dut_i (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .frameStart(frameStart),
    .frameEnd(frameEnd), .frameOk(frameOk), .cmdWord(cmdWord),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (watchIrq && !irqOut) irqDropped = 1;
    while (qTag.size() > 0) begin
      string t;
      logic [7:0] es;
      logic ei;
      t  = qTag.pop_front();
      es = qStatus.pop_front();
      ei = qIrq.pop_front();
      testsRun++;
      if (statusOut !== es || irqOut !== ei) begin
        testsFailed++;
        $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                 t, statusOut, irqOut, es, ei);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectOut(input string tag, input logic [7:0] st, input logic irq);
    qTag.push_back(tag);
    qStatus.push_back(st);
    qIrq.push_back(irq);
    step(1);
  endtask

  task automatic pulseFault(input logic [7:0] bits);
    faultIn = bits;
    step(3);
    faultIn = '0;
    step(6);
  endtask

  task automatic sendFrame(input logic [7:0] cmd, input logic ok);
    frameStart = 1; step(1); frameStart = 0;
    step(2);
    frameEnd = 1; cmdWord = cmd; frameOk = ok;
    step(1);
    frameEnd = 0; frameOk = 0;
    step(3);
  endtask

  initial begin
    step(3);
    rstN = 1;
    step(2);
    expectOut("R7 reset state", 8'h00, 0);

    pulseFault(8'h01);
    expectOut("R1 latch holds after pulse", 8'h01, 0);
    sendFrame(8'h21, 1);
    expectOut("R2 mask low enables irq", 8'h01, 1);

    sendFrame(8'h00, 1);
    expectOut("R6 null read", 8'h01, 1);
    sendFrame(8'hA5, 1);
    expectOut("R6 unassigned code", 8'h01, 1);

    sendFrame(8'h61, 0);
    expectOut("R4 clear with bad frame", 8'h01, 1);
    sendFrame(8'h20, 0);
    expectOut("R4 mask with bad frame", 8'h01, 1);

    sendFrame(8'h61, 1);
    expectOut("R3 clear low group", 8'h00, 0);

    faultIn = 8'h20; step(6);
    sendFrame(8'h32, 1);
    expectOut("R2 mask high enables irq", 8'h20, 1);
    sendFrame(8'h72, 1);
    expectOut("R5 live fault survives clear", 8'h20, 1);
    faultIn = 8'h00; step(6);
    sendFrame(8'h72, 1);
    expectOut("R3 clear high group", 8'h00, 0);

    pulseFault(8'h40);
    expectOut("R1 masked latch", 8'h40, 0);
    frameStart = 1; step(1); frameStart = 0;
    faultIn = 8'h40; step(3);
    faultIn = 8'h00; step(5);
    frameEnd = 1; cmdWord = 8'h74; frameOk = 1;
    step(1);
    frameEnd = 0; frameOk = 0;
    step(3);
    expectOut("R8 change blocks clear", 8'h40, 0);
    sendFrame(8'h74, 1);
    expectOut("R8 later clear works", 8'h00, 0);

    pulseFault(8'h11);
    sendFrame(8'h31, 1);
    expectOut("R2 two enabled flags", 8'h11, 1);
    watchIrq = 1; irqDropped = 0;
    sendFrame(8'h61, 1);
    expectOut("R9 irq held after partial clear", 8'h10, 1);
    watchIrq = 0;
    testsRun++;
    if (irqDropped) begin
      testsFailed++;
      $display("FAIL R9 irq glitch: dropped=1 expected dropped=0");
    end
    sendFrame(8'h71, 1);
    expectOut("R2 irq low after last clear", 8'h00, 0);

    pulseFault(8'h03);
    sendFrame(8'h62, 1);
    expectOut("R3 selective clear", 8'h01, 1);
    sendFrame(8'h7F, 1);
    expectOut("R3 high clear spares low group", 8'h01, 1);
    sendFrame(8'h61, 1);
    expectOut("R3 final clear", 8'h00, 0);

    step(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule